// File: doc/BRIEF.md
# Page Access Rights and Fault Code

This block sits after a page-table walker. It takes the rights that the walk collected (user, writable, no-execute), the leaf entry's dirty bit and 4-bit protection key, and the walk outcome. It combines these with the current access (read, write or fetch), the privilege of the access, the paging control bits and the 32-bit protection-key rights register. From them it produces the permission mask to install for the page, a fault flag, and the page-fault error code. The result is registered, so it appears one clock after the request.

The permission mask includes several adjustments. Supervisor writes may override a read-only page when write-protect is off. Supervisor fetches from user pages are blocked when supervisor-execute prevention is on. Protection keys remove rights. Write permission is held back on a page that is not dirty yet, unless the access is itself the write that will dirty it. On a fault, the error code records why the access failed and what kind of access it was. The mask is then all zero.

Top module: `pgr_access_check`

## Requirements
- R1: A request with `in_valid` high produces its result on the outputs one clock later, with `out_valid` high. A cycle with `in_valid` low drops `out_valid` the next clock. Synchronous reset clears `out_valid`, `perm`, `fault` and `err_code` to zero.
- R2: A user access (`acc_user`=1) to a page whose user bit is clear is a protection fault. It sets error-code P and does not set PK.
- R3: Write permission is granted when the page is writable, or when the access is supervisor mode and `ctl_wp` is 0.
- R4: Execute permission is granted only when the page's no-execute bit is clear. It is also refused when `ctl_smep` is on, the page is a user page and the access is supervisor mode.
- R5: Protection keys take effect only when `ctl_pke`, `ctl_lma` and the page user bit are all 1 and `pkru_val` is nonzero. Key k reads access-disable from `pkru_val` bit 2k and write-disable from bit 2k+1.
- R6: Key access-disable removes read and write. Key write-disable removes write only for a user access, or when `ctl_wp` is 1. When a key removes the right the access needs, the access faults with error-code PK and P set.
- R7: Error-code bits are P=bit0, W=bit1 (the access is a write), U=bit2 (the access is user mode), RSVD=bit3, I/D=bit4 and PK=bit5. They are nonzero only when `fault` is 1.
- R8: I/D is set for a faulting fetch only when (`ctl_nxe` and `ctl_pae`) are both on, or `ctl_smep` is on.
- R9: `walk_status` is encoded as 0 = completed, 1 = not present, 2 = reserved bit set. Not-present faults leave P clear. Reserved-bit faults set both P and RSVD.
- R10: When the entry's dirty bit is 0 and the access is not a write, the write bit of `perm` is 0.
- R11: `acc_type` is encoded as 0 = read, 1 = write, 2 = fetch. `perm` is encoded as bit0 read, bit1 write, bit2 execute. An access whose right is missing from the mask faults with P set. A faulting result reports `perm`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| walk_status | input | 2 | Walk outcome: 0 completed, 1 not present, 2 reserved bit |
| pg_user | input | 1 | Combined user right of the walk |
| pg_write | input | 1 | Combined writable right of the walk |
| pg_nx | input | 1 | Combined no-execute bit of the walk |
| pg_dirty | input | 1 | Dirty bit of the leaf entry |
| pg_key | input | 4 | Protection key of the leaf entry |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch |
| acc_user | input | 1 | Access made in user mode |
| ctl_wp | input | 1 | Supervisor write-protect enable |
| ctl_nxe | input | 1 | No-execute enable |
| ctl_pae | input | 1 | Physical address extension mode |
| ctl_smep | input | 1 | Supervisor-execute prevention |
| ctl_pke | input | 1 | Protection-key enable |
| ctl_lma | input | 1 | Long mode active |
| pkru_val | input | 32 | Protection-key rights register |
| out_valid | output | 1 | Result valid |
| perm | output | 3 | Granted rights: bit0 read, bit1 write, bit2 execute |
| fault | output | 1 | Access faults |
| err_code | output | 6 | Page-fault error code |

## Verification
The assertions check several rules on every cycle. They check the valid pipeline and the all-zero mask on faults. They check that the error code is clear on a good result. They check the U and W flags against the registered request, the PK flag against the key-enable gating, the user-page violation, and the clean-page hold-back of write. Other behaviours depend on how several inputs combine, and only the bench's scenarios can show them. These are the exact selection of PKRU bits by key, the precedence between a key denial and a plain protection denial, the SMEP and write-protect overrides, the I/D conditions, and the not-present versus reserved-bit encodings.

// File: rtl/pgr_pkg.sv
// Package: shared encodings for the page access rights checker.
// Assumes: access type and walk status are 2-bit codes; perm bit order R,W,X.
package pgr_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        WALK_OK     = 2'd0,
        WALK_ABSENT = 2'd1,
        WALK_RSVD   = 2'd2
    } walk_e;

    localparam int PERM_W = 3;
    localparam int PRM_R  = 0;
    localparam int PRM_WR = 1;
    localparam int PRM_X  = 2;

    localparam int ERR_W   = 6;
    localparam int EC_P    = 0;
    localparam int EC_WR   = 1;
    localparam int EC_US   = 2;
    localparam int EC_RSVD = 3;
    localparam int EC_ID   = 4;
    localparam int EC_PK   = 5;
endpackage

// File: rtl/pgr_base_rights.sv
// Module: pgr_base_rights
// Computes the rights that page bits and privilege controls grant before
// protection keys, and flags a user access to a supervisor-only page.
// Assumes: inputs are the already-combined rights of every walk level.
module pgr_base_rights
    import pgr_pkg::*;
(
    input  logic              pg_user,
    input  logic              pg_write,
    input  logic              pg_nx,
    input  logic              acc_user,
    input  logic              ctl_wp,
    input  logic              ctl_smep,
    output logic [PERM_W-1:0] base_perm,
    output logic              user_viol
);
    // Purpose: apply write-protect override and supervisor-execute prevention.
    always_comb begin
        base_perm         = '0;
        base_perm[PRM_R]  = 1'b1;
        base_perm[PRM_WR] = pg_write | (~acc_user & ~ctl_wp);
        base_perm[PRM_X]  = ~pg_nx & (acc_user | ~(ctl_smep & pg_user));
        user_viol         = acc_user & ~pg_user;
    end
endmodule

// File: rtl/pgr_key_rights.sv
// Module: pgr_key_rights
// Decodes the protection-key rights register into per-key disable bits and
// yields a mask of rights left by the selected key.
// Assumes: two rights bits per key, access-disable at 2k, write-disable at 2k+1.
module pgr_key_rights
    import pgr_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic [KEY_W-1:0]         pg_key,
    input  logic [2*(2**KEY_W)-1:0]  pkru_val,
    input  logic                     pg_user,
    input  logic                     acc_user,
    input  logic                     ctl_wp,
    input  logic                     ctl_pke,
    input  logic                     ctl_lma,
    output logic [PERM_W-1:0]        key_mask
);
    localparam int NKEYS = 2**KEY_W;

    logic [NKEYS-1:0] ad_vec;
    logic [NKEYS-1:0] wd_vec;

    // Purpose: split the rights register into disable bits per key.
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        assign ad_vec[k] = pkru_val[2*k];
        assign wd_vec[k] = pkru_val[2*k+1];
    end

    logic keys_on;
    logic sel_ad;
    logic sel_wd;

    // Purpose: gate keys and strip rights for the selected key.
    always_comb begin
        keys_on  = ctl_pke & ctl_lma & pg_user & (|pkru_val);
        sel_ad   = ad_vec[pg_key];
        sel_wd   = wd_vec[pg_key];
        key_mask = '1;
        if (keys_on) begin
            if (sel_ad) begin
                key_mask[PRM_R]  = 1'b0;
                key_mask[PRM_WR] = 1'b0;
            end else if (sel_wd && (acc_user || ctl_wp)) begin
                key_mask[PRM_WR] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgr_fault_code.sv
// Module: pgr_fault_code
// Resolves fault precedence and assembles the page-fault error code.
// Assumes: walk faults take precedence over rights checks; user violation
// precedes key checks; key denial precedes a plain mask denial.
module pgr_fault_code
    import pgr_pkg::*;
(
    input  logic [1:0]       walk_status,
    input  logic [1:0]       acc_type,
    input  logic             acc_user,
    input  logic             ctl_nxe,
    input  logic             ctl_pae,
    input  logic             ctl_smep,
    input  logic             user_viol,
    input  logic             key_deny,
    input  logic             mask_deny,
    output logic             fault,
    output logic [ERR_W-1:0] err_code
);
    logic absent;
    logic rsvd;
    logic protect;
    logic pk_hit;

    // Purpose: classify the fault cause with fixed precedence.
    always_comb begin
        absent  = (walk_status == WALK_ABSENT);
        rsvd    = (walk_status == WALK_RSVD);
        pk_hit  = (walk_status == WALK_OK) & ~user_viol & key_deny;
        protect = rsvd | ((walk_status == WALK_OK) &
                          (user_viol | key_deny | mask_deny));
        fault   = absent | protect;
    end

    // Purpose: build the error code bits for a faulting access.
    always_comb begin
        err_code = '0;
        if (fault) begin
            err_code[EC_P]    = protect;
            err_code[EC_RSVD] = rsvd;
            err_code[EC_WR]   = (acc_type == ACC_WRITE);
            err_code[EC_US]   = acc_user;
            err_code[EC_ID]   = (acc_type == ACC_FETCH) &
                                ((ctl_nxe & ctl_pae) | ctl_smep);
            err_code[EC_PK]   = pk_hit;
        end
    end
endmodule

// File: rtl/pgr_access_check.sv
// Module: pgr_access_check (top)
// Evaluates the rights of a finished page walk for one access and registers
// the permission mask, fault flag and error code one clock later.
// Assumes: one request per cycle when in_valid is high; outputs hold when idle.
module pgr_access_check
    import pgr_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  walk_status,
    input  logic        pg_user,
    input  logic        pg_write,
    input  logic        pg_nx,
    input  logic        pg_dirty,
    input  logic [3:0]  pg_key,
    input  logic [1:0]  acc_type,
    input  logic        acc_user,
    input  logic        ctl_wp,
    input  logic        ctl_nxe,
    input  logic        ctl_pae,
    input  logic        ctl_smep,
    input  logic        ctl_pke,
    input  logic        ctl_lma,
    input  logic [31:0] pkru_val,
    output logic        out_valid,
    output logic [2:0]  perm,
    output logic        fault,
    output logic [5:0]  err_code
);
    logic [PERM_W-1:0] base_perm;
    logic [PERM_W-1:0] key_mask;
    logic [PERM_W-1:0] eff_perm;
    logic [PERM_W-1:0] rep_perm;
    logic              user_viol;
    logic              key_deny;
    logic              mask_deny;
    logic              nxt_fault;
    logic [ERR_W-1:0]  nxt_err;
    logic [1:0]        acc_idx;

    pgr_base_rights i_base (
        .pg_user   (pg_user),
        .pg_write  (pg_write),
        .pg_nx     (pg_nx),
        .acc_user  (acc_user),
        .ctl_wp    (ctl_wp),
        .ctl_smep  (ctl_smep),
        .base_perm (base_perm),
        .user_viol (user_viol)
    );

    pgr_key_rights #(.KEY_W(KEY_W)) i_key (
        .pg_key   (pg_key[KEY_W-1:0]),
        .pkru_val (pkru_val[2*(2**KEY_W)-1:0]),
        .pg_user  (pg_user),
        .acc_user (acc_user),
        .ctl_wp   (ctl_wp),
        .ctl_pke  (ctl_pke),
        .ctl_lma  (ctl_lma),
        .key_mask (key_mask)
    );

    // Purpose: merge rights, test the needed right, hold write on clean pages.
    always_comb begin
        acc_idx   = (acc_type == ACC_FETCH) ? 2'(PRM_X) :
                    (acc_type == ACC_WRITE) ? 2'(PRM_WR) : 2'(PRM_R);
        eff_perm  = base_perm & key_mask;
        key_deny  = ~key_mask[acc_idx];
        mask_deny = ~base_perm[acc_idx];
        rep_perm  = eff_perm;
        if (!pg_dirty && acc_type != ACC_WRITE) begin
            rep_perm[PRM_WR] = 1'b0;
        end
    end

    pgr_fault_code i_code (
        .walk_status (walk_status),
        .acc_type    (acc_type),
        .acc_user    (acc_user),
        .ctl_nxe     (ctl_nxe),
        .ctl_pae     (ctl_pae),
        .ctl_smep    (ctl_smep),
        .user_viol   (user_viol),
        .key_deny    (key_deny),
        .mask_deny   (mask_deny),
        .fault       (nxt_fault),
        .err_code    (nxt_err)
    );

    // Purpose: register the result of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            perm      <= '0;
            fault     <= 1'b0;
            err_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                perm     <= nxt_fault ? '0 : rep_perm;
                fault    <= nxt_fault;
                err_code <= nxt_err;
            end
        end
    end
endmodule

// File: rtl/pgr_access_check_sva.sv
// Module: pgr_access_check_sva
// Checker bound to pgr_access_check; relates registered outputs to the
// request of the previous cycle.
module pgr_access_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  walk_status,
    input logic        pg_user,
    input logic        pg_dirty,
    input logic [1:0]  acc_type,
    input logic        acc_user,
    input logic        ctl_pke,
    input logic        ctl_lma,
    input logic        out_valid,
    input logic [2:0]  perm,
    input logic        fault,
    input logic [5:0]  err_code
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_user_viol_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && walk_status == 2'd0 && acc_user && !pg_user)
        |=> (fault && err_code[0] && !err_code[5]));

    p_pk_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(ctl_pke && ctl_lma && pg_user)) |=> !err_code[5]);

    p_user_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!fault || err_code[2] == $past(acc_user)));

    p_write_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!fault || err_code[1] == ($past(acc_type) == 2'd1)));

    p_clean_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !fault) |-> err_code == 6'd0);

    p_clean_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pg_dirty && acc_type != 2'd1) |=> !perm[1]);

    p_fault_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fault) |-> perm == 3'd0);
endmodule

bind pgr_access_check pgr_access_check_sva i_pgr_access_check_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .walk_status (walk_status),
    .pg_user     (pg_user),
    .pg_dirty    (pg_dirty),
    .acc_type    (acc_type),
    .acc_user    (acc_user),
    .ctl_pke     (ctl_pke),
    .ctl_lma     (ctl_lma),
    .out_valid   (out_valid),
    .perm        (perm),
    .fault       (fault),
    .err_code    (err_code)
);

// File: tb/test_pgr_access_check.sv
module test_pgr_access_check;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  walk_status;
    logic        pg_user, pg_write, pg_nx, pg_dirty;
    logic [3:0]  pg_key;
    logic [1:0]  acc_type;
    logic        acc_user;
    logic        ctl_wp, ctl_nxe, ctl_pae, ctl_smep, ctl_pke, ctl_lma;
    logic [31:0] pkru_val;
    logic        out_valid;
    logic [2:0]  perm;
    logic        fault;
    logic [5:0]  err_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pgr_access_check i_pgr_access_check (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .walk_status(walk_status),
        .pg_user(pg_user), .pg_write(pg_write), .pg_nx(pg_nx), .pg_dirty(pg_dirty),
        .pg_key(pg_key), .acc_type(acc_type), .acc_user(acc_user), .ctl_wp(ctl_wp),
        .ctl_nxe(ctl_nxe), .ctl_pae(ctl_pae), .ctl_smep(ctl_smep), .ctl_pke(ctl_pke),
        .ctl_lma(ctl_lma), .pkru_val(pkru_val), .out_valid(out_valid), .perm(perm),
        .fault(fault), .err_code(err_code)
    );

    typedef struct packed {
        logic [1:0]  st;
        logic        u, w, nx, d;
        logic [3:0]  key;
        logic [1:0]  acc;
        logic        usr, wp, nxe, pae, smep, pke, lma;
        logic [31:0] pkru;
        logic [2:0]  eperm;
        logic        efault;
        logic [5:0]  eerr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // R3 user read of user page, full rights
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd0,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd7,1'b0,6'd0,4'd3},
        // R2 user read of supervisor page
        '{2'd0,1'b0,1'b1,1'b0,1'b1,4'd0,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd0,1'b1,6'd5,4'd2},
        // R3 supervisor write to read-only page, wp off
        '{2'd0,1'b0,1'b0,1'b0,1'b1,4'd0,2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd7,1'b0,6'd0,4'd3},
        // R11 supervisor write to read-only page, wp on
        '{2'd0,1'b0,1'b0,1'b0,1'b1,4'd0,2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd0,1'b1,6'd3,4'd11},
        // R4 supervisor fetch of user page with smep
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,3'd0,1'b1,6'd17,4'd4},
        // R4 supervisor read of user page with smep: no execute
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,3'd3,1'b0,6'd0,4'd4},
        // R8 user fetch of nx page, nxe+pae
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'd0,2'd2,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd0,1'b1,6'd21,4'd8},
        // R8 same, nxe off: no I/D
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'd0,2'd2,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,3'd0,1'b1,6'd5,4'd8},
        // R6 key 3 access-disable on user read
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd3,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,32'h40,3'd0,1'b1,6'd37,4'd6},
        // R6 key 2 write-disable on user write
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd2,2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,32'h20,3'd0,1'b1,6'd39,4'd6},
        // R6 key 2 write-disable on user read
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd2,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,32'h20,3'd5,1'b0,6'd0,4'd6},
        // R6 write-disable ignored for supervisor with wp off
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd2,2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,32'h20,3'd7,1'b0,6'd0,4'd6},
        // R5 keys inactive without long mode
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd3,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,32'h40,3'd7,1'b0,6'd0,4'd5},
        // R5 disable bit of another key has no effect
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'd3,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,32'h10,3'd7,1'b0,6'd0,4'd5},
        // R9 not-present user write
        '{2'd1,1'b1,1'b1,1'b0,1'b1,4'd0,2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd0,1'b1,6'd6,4'd9},
        // R9 reserved-bit supervisor read
        '{2'd2,1'b1,1'b1,1'b0,1'b1,4'd0,2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd0,1'b1,6'd9,4'd9},
        // R10 clean page read: write held back
        '{2'd0,1'b1,1'b1,1'b0,1'b0,4'd0,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd5,1'b0,6'd0,4'd10},
        // R10 clean page write keeps write
        '{2'd0,1'b1,1'b1,1'b0,1'b0,4'd0,2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,3'd7,1'b0,6'd0,4'd10},
        // R8 not-present fetch, nxe without pae: error code zero
        '{2'd1,1'b1,1'b1,1'b0,1'b1,4'd0,2'd2,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,3'd0,1'b1,6'd0,4'd8}
    };

    task automatic chk(input int rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        walk_status = v.st; pg_user = v.u; pg_write = v.w; pg_nx = v.nx;
        pg_dirty = v.d; pg_key = v.key; acc_type = v.acc; acc_user = v.usr;
        ctl_wp = v.wp; ctl_nxe = v.nxe; ctl_pae = v.pae; ctl_smep = v.smep;
        ctl_pke = v.pke; ctl_lma = v.lma; pkru_val = v.pkru;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1;
        drive(TBL[0]);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(1, "reset out_valid", int'(out_valid), 0);
        chk(1, "reset perm", int'(perm), 0);
        chk(1, "reset fault", int'(fault), 0);
        chk(1, "reset err_code", int'(err_code), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            in_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk(int'(TBL[i].rq), "valid", int'(out_valid), 1);
            chk(int'(TBL[i].rq), "perm", int'(perm), int'(TBL[i].eperm));
            chk(int'(TBL[i].rq), "fault", int'(fault), int'(TBL[i].efault));
            chk(int'(TBL[i].rq), "err_code", int'(err_code), int'(TBL[i].eerr));
        end
        // R1 idle cycle drops valid and holds result
        drive(TBL[1]);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(1, "idle out_valid", int'(out_valid), 0);
        chk(1, "idle hold err_code", int'(err_code), 0);
        // R5 nonzero-only gate: pkru zero leaves user read intact
        drive(TBL[8]); pkru_val = 32'h0; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(5, "pkru zero perm", int'(perm), 7);
        // R5 highest key selects bits 30 and 31
        drive(TBL[8]); pg_key = 4'd15; pkru_val = 32'h8000_0000; acc_type = 2'd1;
        @(posedge clk); @(negedge clk);
        chk(5, "key15 write-disable err", int'(err_code), 39);
        // R2 user violation wins over key denial: no PK
        drive(TBL[8]); pg_user = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(2, "user viol no PK", int'(err_code), 5);
        // R1 reset mid-run clears outputs
        drive(TBL[3]);
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(1, "mid reset fault", int'(fault), 0);
        chk(1, "mid reset err", int'(err_code), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule